// File: doc/BRIEF.md
# Privilege-Change Stack Pointer Selector

This block picks the stack that an interrupt or exception handler starts on. When a delivery request arrives, it compares the privilege level of the code that was interrupted with the privilege level of the handler. It also looks at the alternate-stack slot number that the interrupt descriptor names and at whether the task register currently refers to a usable task-state structure. From these it decides one of three outcomes: load a new stack selector and stack pointer, stay on the current stack, or raise an invalid-task-state fault with vector 10. Walking descriptor tables and pushing the interrupt frame belong to neighbouring logic.

The stack values live in a small register file. It holds a selector and a pointer for each of the inner privilege levels 0, 1 and 2, plus seven alternate-stack pointers. Software-side logic loads it through a simple indexed write port. A mode input chooses between full 64-bit pointers and 32-bit operation; in 32-bit operation only the low half of a stored pointer is delivered.

The decision is registered. A controller state machine has the states IDLE, SWITCH, KEEP and FAULT. A request strobe moves it into SWITCH, KEEP or FAULT on the next edge (transitions "decide"). Without a strobe it returns to IDLE (transition "retire"). A strobe while it is already in a result state starts the next decision directly (transition "chain").

Top module: `stksel_top`

## Requirements
- R1: After reset all result flags, the fault vector, the delivered selector and the delivered pointer are zero, and every register-file entry reads as zero.
- R2: The write port uses a 4-bit index. Indices 1 to 7 load alternate-stack pointer 1 to 7, indices 8, 9 and 10 load the level 0, 1 and 2 pointers, and indices 12, 13 and 14 load the level 0, 1 and 2 selectors (low 16 bits of the data). Writes to indices 0, 11 and 15 change no entry.
- R3: A request whose alternate-stack slot is 0 and whose target level is numerically lower than the current level (for example 3 to 0) delivers the target level's selector and pointer with the stack-valid flag set.
- R4: A request with a nonzero slot n (1 to 7) always needs a new stack. It delivers alternate-stack pointer n in place of the per-level pointer, together with the target level's selector, or a zero selector when the target level is 3.
- R5: A request with slot 0 and a target level equal to or numerically higher than the current level sets the keep-current-stack flag only. This holds even when the task register reference is invalid, and the delivered selector and pointer stay unchanged.
- R6: A request that needs a new stack while the task register reference is invalid sets the fault flag with a fault vector of 10. Stack-valid and keep-current-stack stay low, and the delivered selector and pointer keep their previous values.
- R7: With the mode input low (32-bit operation), the upper 32 bits of a delivered pointer are zero. With it high, all 64 bits are delivered.
- R8: Each result appears in the clock cycle right after the cycle in which the request strobe is high, and lasts one cycle unless another strobe follows. At most one of stack-valid, keep-current-stack and fault is high at a time, and none is high without a strobe in the cycle before. The delivered selector and pointer change only with a new stack-valid result.
- R9: Back-to-back strobes each produce their own result. A write in the same cycle as a strobe takes effect for later requests only; the request in that cycle sees the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Delivery request strobe |
| cur_pl | input | 2 | Privilege level of the interrupted code |
| tgt_pl | input | 2 | Privilege level of the handler |
| ist_idx | input | 3 | Alternate-stack slot from the descriptor, 0 means none |
| tr_valid | input | 1 | Task register refers to a usable task-state structure |
| long_mode | input | 1 | 1 selects 64-bit pointers, 0 selects 32-bit operation |
| wr_en | input | 1 | Register-file write enable |
| wr_idx | input | 4 | Register-file entry index |
| wr_data | input | 64 | Register-file write data |
| out_valid | output | 1 | New stack delivered this cycle |
| out_sel | output | 16 | Delivered stack selector |
| out_ptr | output | 64 | Delivered stack pointer |
| keep_stack | output | 1 | Handler stays on the current stack |
| fault | output | 1 | Invalid-task-state fault raised |
| fault_vec | output | 8 | Fault vector, 10 while fault is high, else 0 |

## Verification
Every result (stack-valid, keep, fault with its vector, and the delivered selector and pointer) is due exactly one rising edge after the cycle in which the strobe is high. Register-file writes count from that same edge, and the request in the write cycle still sees the old entry. The bench's reference model advances on each rising edge from the inputs it drove half a cycle earlier. All outputs are compared with the model on every falling edge, so each comparison falls in the middle of the cycle the result belongs to. Directed checks at the same sampling point pin literal values for the reset state, the 32-bit masking and the write-versus-request ordering.

// File: rtl/stksel_pkg.sv
package stksel_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SWITCH = 2'd1,
        ST_KEEP   = 2'd2,
        ST_FAULT  = 2'd3
    } stksel_state_e;

    localparam logic [7:0] BAD_TASK_STATE_VEC = 8'd10;

endpackage

// File: rtl/stksel_regfile.sv
module stksel_regfile #(
    parameter int PTR_W     = 64,
    parameter int SEL_W     = 16,
    parameter int NUM_LVL   = 3,
    parameter int NUM_IST   = 7,
    parameter int IDX_W     = 4,
    parameter int IST_BASE  = 1,
    parameter int LPTR_BASE = 8,
    parameter int LSEL_BASE = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [PTR_W-1:0]           wr_data,
    output logic [NUM_LVL*PTR_W-1:0]   lvl_ptr,
    output logic [NUM_LVL*SEL_W-1:0]   lvl_sel,
    output logic [NUM_IST*PTR_W-1:0]   ist_ptr
);

    // Alternate-stack pointers, slot n lives at index IST_BASE + n - 1
    for (genvar g = 0; g < NUM_IST; g++) begin : g_ist
        logic [PTR_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(IST_BASE + g))) begin
                q <= wr_data;
            end
        end
        assign ist_ptr[g*PTR_W +: PTR_W] = q;
    end

    // Per-level pointer and selector pairs
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        logic [PTR_W-1:0] p_q;
        logic [SEL_W-1:0] s_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                p_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(LPTR_BASE + l))) begin
                p_q <= wr_data;
            end
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                s_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(LSEL_BASE + l))) begin
                s_q <= wr_data[SEL_W-1:0];
            end
        end
        assign lvl_ptr[l*PTR_W +: PTR_W] = p_q;
        assign lvl_sel[l*SEL_W +: SEL_W] = s_q;
    end

endmodule

// File: rtl/stksel_decide.sv
module stksel_decide
    import stksel_pkg::*;
#(
    parameter int PTR_W    = 64,
    parameter int SEL_W    = 16,
    parameter int NUM_LVL  = 3,
    parameter int NUM_IST  = 7,
    parameter int PL_W     = 2,
    parameter int IST_W    = 3,
    parameter int NARROW_W = 32
) (
    input  logic [PL_W-1:0]            cur_pl,
    input  logic [PL_W-1:0]            tgt_pl,
    input  logic [IST_W-1:0]           ist_idx,
    input  logic                       tr_valid,
    input  logic                       long_mode,
    input  logic [NUM_LVL*PTR_W-1:0]   lvl_ptr,
    input  logic [NUM_LVL*SEL_W-1:0]   lvl_sel,
    input  logic [NUM_IST*PTR_W-1:0]   ist_ptr,
    output stksel_state_e              kind,
    output logic [SEL_W-1:0]           nxt_sel,
    output logic [PTR_W-1:0]           nxt_ptr
);

    localparam logic [PTR_W-1:0] NARROW_MASK =
        {{(PTR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic             use_alt;
    logic             inward;
    logic             need_new;
    logic [PTR_W-1:0] lvl_pick;
    logic [PTR_W-1:0] alt_pick;
    logic [PTR_W-1:0] raw_ptr;

    assign use_alt  = (ist_idx != '0);
    assign inward   = (tgt_pl < cur_pl);
    assign need_new = use_alt || inward;

    always_comb begin
        nxt_sel  = '0;
        lvl_pick = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (tgt_pl == PL_W'(i)) begin
                nxt_sel  = lvl_sel[i*SEL_W +: SEL_W];
                lvl_pick = lvl_ptr[i*PTR_W +: PTR_W];
            end
        end
    end

    always_comb begin
        alt_pick = '0;
        for (int i = 0; i < NUM_IST; i++) begin
            if (ist_idx == IST_W'(i + 1)) begin
                alt_pick = ist_ptr[i*PTR_W +: PTR_W];
            end
        end
    end

    assign raw_ptr = use_alt ? alt_pick : lvl_pick;
    assign nxt_ptr = long_mode ? raw_ptr : (raw_ptr & NARROW_MASK);

    always_comb begin
        if (!need_new) begin
            kind = ST_KEEP;
        end else if (!tr_valid) begin
            kind = ST_FAULT;
        end else begin
            kind = ST_SWITCH;
        end
    end

endmodule

// File: rtl/stksel_ctrl.sv
module stksel_ctrl
    import stksel_pkg::*;
#(
    parameter int PTR_W = 64,
    parameter int SEL_W = 16,
    parameter int VEC_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req,
    input  stksel_state_e       kind,
    input  logic [SEL_W-1:0]    nxt_sel,
    input  logic [PTR_W-1:0]    nxt_ptr,
    output logic                out_valid,
    output logic [SEL_W-1:0]    out_sel,
    output logic [PTR_W-1:0]    out_ptr,
    output logic                keep_stack,
    output logic                fault,
    output logic [VEC_W-1:0]    fault_vec
);

    stksel_state_e state_q;
    stksel_state_e state_d;

    // Next state: decide / chain on a strobe, retire otherwise
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE:   state_d = req ? kind : ST_IDLE;
            ST_SWITCH: state_d = req ? kind : ST_IDLE;
            ST_KEEP:   state_d = req ? kind : ST_IDLE;
            ST_FAULT:  state_d = req ? kind : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Delivered stack, loaded only on a switch decision
    always_ff @(posedge clk) begin
        if (rst) begin
            out_sel <= '0;
            out_ptr <= '0;
        end else if (req && (kind == ST_SWITCH)) begin
            out_sel <= nxt_sel;
            out_ptr <= nxt_ptr;
        end
    end

    always_comb begin
        out_valid  = 1'b0;
        keep_stack = 1'b0;
        fault      = 1'b0;
        fault_vec  = '0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_SWITCH: out_valid = 1'b1;
            ST_KEEP:   keep_stack = 1'b1;
            ST_FAULT: begin
                fault     = 1'b1;
                fault_vec = VEC_W'(BAD_TASK_STATE_VEC);
            end
        endcase
    end

endmodule

// File: rtl/stksel_top.sv
module stksel_top
    import stksel_pkg::*;
#(
    parameter int PTR_W    = 64,
    parameter int SEL_W    = 16,
    parameter int PL_W     = 2,
    parameter int IST_W    = 3,
    parameter int IDX_W    = 4,
    parameter int VEC_W    = 8,
    parameter int NARROW_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req,
    input  logic [PL_W-1:0]     cur_pl,
    input  logic [PL_W-1:0]     tgt_pl,
    input  logic [IST_W-1:0]    ist_idx,
    input  logic                tr_valid,
    input  logic                long_mode,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [PTR_W-1:0]    wr_data,
    output logic                out_valid,
    output logic [SEL_W-1:0]    out_sel,
    output logic [PTR_W-1:0]    out_ptr,
    output logic                keep_stack,
    output logic                fault,
    output logic [VEC_W-1:0]    fault_vec
);

    localparam int NUM_LVL   = (1 << PL_W) - 1;
    localparam int NUM_IST   = (1 << IST_W) - 1;
    localparam int IST_BASE  = 1;
    localparam int LPTR_BASE = 1 << (IDX_W - 1);
    localparam int LSEL_BASE = LPTR_BASE + (1 << (IDX_W - 2));

    logic [NUM_LVL*PTR_W-1:0] lvl_ptr;
    logic [NUM_LVL*SEL_W-1:0] lvl_sel;
    logic [NUM_IST*PTR_W-1:0] ist_ptr;
    stksel_state_e            kind;
    logic [SEL_W-1:0]         nxt_sel;
    logic [PTR_W-1:0]         nxt_ptr;

    stksel_regfile #(
        .PTR_W(PTR_W), .SEL_W(SEL_W), .NUM_LVL(NUM_LVL), .NUM_IST(NUM_IST),
        .IDX_W(IDX_W), .IST_BASE(IST_BASE), .LPTR_BASE(LPTR_BASE),
        .LSEL_BASE(LSEL_BASE)
    ) u_rf (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .lvl_ptr(lvl_ptr), .lvl_sel(lvl_sel),
        .ist_ptr(ist_ptr)
    );

    stksel_decide #(
        .PTR_W(PTR_W), .SEL_W(SEL_W), .NUM_LVL(NUM_LVL), .NUM_IST(NUM_IST),
        .PL_W(PL_W), .IST_W(IST_W), .NARROW_W(NARROW_W)
    ) u_dec (
        .cur_pl(cur_pl), .tgt_pl(tgt_pl), .ist_idx(ist_idx),
        .tr_valid(tr_valid), .long_mode(long_mode), .lvl_ptr(lvl_ptr),
        .lvl_sel(lvl_sel), .ist_ptr(ist_ptr), .kind(kind),
        .nxt_sel(nxt_sel), .nxt_ptr(nxt_ptr)
    );

    stksel_ctrl #(
        .PTR_W(PTR_W), .SEL_W(SEL_W), .VEC_W(VEC_W)
    ) u_ctl (
        .clk(clk), .rst(rst), .req(req), .kind(kind), .nxt_sel(nxt_sel),
        .nxt_ptr(nxt_ptr), .out_valid(out_valid), .out_sel(out_sel),
        .out_ptr(out_ptr), .keep_stack(keep_stack), .fault(fault),
        .fault_vec(fault_vec)
    );

endmodule

// File: rtl/stksel_chk.sv
module stksel_chk #(
    parameter int PTR_W    = 64,
    parameter int SEL_W    = 16,
    parameter int PL_W     = 2,
    parameter int IST_W    = 3,
    parameter int VEC_W    = 8,
    parameter int NARROW_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic [PL_W-1:0]   cur_pl,
    input logic [PL_W-1:0]   tgt_pl,
    input logic [IST_W-1:0]  ist_idx,
    input logic              tr_valid,
    input logic              long_mode,
    input logic              out_valid,
    input logic [SEL_W-1:0]  out_sel,
    input logic [PTR_W-1:0]  out_ptr,
    input logic              keep_stack,
    input logic              fault,
    input logic [VEC_W-1:0]  fault_vec
);

    a_r6_fault_vector: assert property (@(posedge clk) disable iff (rst)
        fault |-> ((fault_vec == VEC_W'(10)) && !out_valid && !keep_stack));

    a_r6_fault_needs_bad_tr: assert property (@(posedge clk) disable iff (rst)
        fault |-> !$past(tr_valid));

    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_valid, keep_stack, fault}));

    a_r8_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        (out_valid || keep_stack || fault) |-> $past(req));

    a_r8_answers_strobe: assert property (@(posedge clk) disable iff (rst)
        req |=> (out_valid || keep_stack || fault));

    a_r8_data_hold: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_ptr) && $stable(out_sel)));

    a_r5_keep: assert property (@(posedge clk) disable iff (rst)
        (req && (ist_idx == '0) && (tgt_pl >= cur_pl)) |=> keep_stack);

    a_r4_alt_switches: assert property (@(posedge clk) disable iff (rst)
        (req && (ist_idx != '0)) |=> !keep_stack);

    a_r7_narrow: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(long_mode)) |-> (out_ptr[PTR_W-1:NARROW_W] == '0));

endmodule

bind stksel_top stksel_chk #(
    .PTR_W(PTR_W), .SEL_W(SEL_W), .PL_W(PL_W), .IST_W(IST_W),
    .VEC_W(VEC_W), .NARROW_W(NARROW_W)
) u_chk (
    .clk(clk), .rst(rst), .req(req), .cur_pl(cur_pl), .tgt_pl(tgt_pl),
    .ist_idx(ist_idx), .tr_valid(tr_valid), .long_mode(long_mode),
    .out_valid(out_valid), .out_sel(out_sel), .out_ptr(out_ptr),
    .keep_stack(keep_stack), .fault(fault), .fault_vec(fault_vec)
);

// File: tb/stksel_top_test.sv
module stksel_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [1:0]  cur_pl = '0;
    logic [1:0]  tgt_pl = '0;
    logic [2:0]  ist_idx = '0;
    logic        tr_valid = 1'b1;
    logic        long_mode = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic        out_valid;
    logic [15:0] out_sel;
    logic [63:0] out_ptr;
    logic        keep_stack;
    logic        fault;
    logic [7:0]  fault_vec;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    stksel_top uut (
        .clk(clk), .rst(rst), .req(req), .cur_pl(cur_pl), .tgt_pl(tgt_pl),
        .ist_idx(ist_idx), .tr_valid(tr_valid), .long_mode(long_mode),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .out_valid(out_valid), .out_sel(out_sel), .out_ptr(out_ptr),
        .keep_stack(keep_stack), .fault(fault), .fault_vec(fault_vec)
    );

    // Behavioural reference model
    logic [63:0] m_alt [1:7];
    logic [63:0] m_lptr [0:2];
    logic [15:0] m_lsel [0:2];
    logic        e_valid, e_keep, e_fault;
    logic [15:0] e_sel;
    logic [63:0] e_ptr;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 1; i <= 7; i++) m_alt[i] = '0;
            for (int i = 0; i <= 2; i++) begin m_lptr[i] = '0; m_lsel[i] = '0; end
            e_valid = 0; e_keep = 0; e_fault = 0; e_sel = '0; e_ptr = '0;
        end else begin
            e_valid = 0; e_keep = 0; e_fault = 0;
            if (req) begin
                int c, t, a;
                logic [63:0] p;
                c = cur_pl; t = tgt_pl; a = ist_idx;
                if (a == 0 && t >= c) e_keep = 1;
                else if (!tr_valid) e_fault = 1;
                else begin
                    e_valid = 1;
                    e_sel = (t <= 2) ? m_lsel[t] : 16'h0;
                    p = (a != 0) ? m_alt[a] : m_lptr[t];
                    if (!long_mode) p[63:32] = '0;
                    e_ptr = p;
                end
            end
            if (wr_en) begin
                int w;
                w = wr_idx;
                if (w >= 1 && w <= 7) m_alt[w] = wr_data;
                else if (w >= 8 && w <= 10) m_lptr[w-8] = wr_data;
                else if (w >= 12 && w <= 14) m_lsel[w-12] = wr_data[15:0];
            end
        end
    end

    task automatic check64(string tag, string what, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    // Every-cycle comparison against the model (R8 timing)
    always @(negedge clk) begin
        if (!rst && !done) begin
            check64(cur_req, "out_valid", 64'(out_valid), 64'(e_valid));
            check64(cur_req, "keep_stack", 64'(keep_stack), 64'(e_keep));
            check64(cur_req, "fault", 64'(fault), 64'(e_fault));
            check64(cur_req, "fault_vec", 64'(fault_vec), e_fault ? 64'd10 : 64'd0);
            check64(cur_req, "out_sel", 64'(out_sel), 64'(e_sel));
            check64(cur_req, "out_ptr", out_ptr, e_ptr);
        end
    end

    function automatic logic [63:0] pat(int idx);
        return 64'hFEDC_0000_0000_0000 | (64'(idx) << 40) | (64'(idx) * 64'h0101_0101);
    endfunction

    // One cycle of stimulus, applied after a falling edge
    task automatic cyc(bit r, int c, int t, int a, bit trv, bit lm,
                       bit we, int wi, logic [63:0] wd);
        req = r; cur_pl = 2'(c); tgt_pl = 2'(t); ist_idx = 3'(a);
        tr_valid = trv; long_mode = lm;
        wr_en = we; wr_idx = 4'(wi); wr_data = wd;
        @(negedge clk);
        req = 0; wr_en = 0;
    endtask

    task automatic ask(int c, int t, int a, bit trv, bit lm);
        cyc(1, c, t, a, trv, lm, 0, 0, '0);
    endtask

    task automatic wr(int wi, logic [63:0] wd);
        cyc(0, 0, 0, 0, 1, 1, 1, wi, wd);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        check64("R1", "flags", 64'({out_valid, keep_stack, fault}), 64'd0);
        check64("R1", "ptr", out_ptr, 64'd0);
        ask(3, 0, 0, 1, 1);
        check64("R1", "level0 ptr after reset", out_ptr, 64'd0);

        // R2: load every entry, then hit unused indices
        cur_req = "R2";
        for (int i = 1; i <= 10; i++) wr(i, pat(i));
        for (int i = 12; i <= 14; i++) wr(i, pat(i));
        wr(0, '1); wr(11, '1); wr(15, '1);
        for (int a = 1; a <= 7; a++) ask(3, 0, a, 1, 1);
        for (int t = 0; t <= 2; t++) ask(3, t, 0, 1, 1);
        check64("R2", "level2 ptr unchanged by idx 11/15", out_ptr, pat(10));

        // R3: inward transitions without alternate stack
        cur_req = "R3";
        ask(3, 0, 0, 1, 1);
        check64("R3", "level0 sel", 64'(out_sel), 64'(pat(12) & 64'hFFFF));
        check64("R3", "level0 ptr", out_ptr, pat(8));
        ask(2, 1, 0, 1, 1);
        ask(1, 0, 0, 1, 1);

        // R4: alternate stack overrides, including target level 3
        cur_req = "R4";
        ask(0, 0, 4, 1, 1);
        check64("R4", "alt4 ptr", out_ptr, pat(4));
        ask(3, 3, 5, 1, 1);
        check64("R4", "sel for level 3", 64'(out_sel), 64'd0);
        ask(3, 1, 7, 1, 1);

        // R5: stay on current stack, even with a bad task register
        cur_req = "R5";
        ask(0, 0, 0, 1, 1);
        ask(1, 2, 0, 0, 1);
        check64("R5", "keep flag", 64'(keep_stack), 64'd1);
        check64("R5", "ptr unchanged", out_ptr, pat(7));

        // R6: invalid task register when a switch is needed
        cur_req = "R6";
        ask(3, 0, 0, 0, 1);
        check64("R6", "fault vector", 64'(fault_vec), 64'd10);
        ask(0, 0, 2, 0, 1);

        // R7: 32-bit operation masks the upper half
        cur_req = "R7";
        ask(3, 1, 0, 1, 0);
        check64("R7", "narrow ptr", out_ptr, pat(9) & 64'h0000_0000_FFFF_FFFF);
        ask(2, 0, 3, 1, 0);

        // R8: back-to-back and idle gaps
        cur_req = "R8";
        ask(3, 0, 0, 1, 1); ask(0, 0, 0, 1, 1); ask(3, 2, 0, 0, 1); ask(3, 2, 0, 1, 1);
        repeat (2) @(negedge clk);

        // R9: write and request in the same cycle
        cur_req = "R9";
        cyc(1, 3, 0, 0, 1, 1, 1, 8, 64'h1234_5678_9ABC_DEF0);
        check64("R9", "old level0 ptr", out_ptr, pat(8));
        ask(3, 0, 0, 1, 1);
        check64("R9", "new level0 ptr", out_ptr, 64'h1234_5678_9ABC_DEF0);
        repeat (2) @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule